// File: doc/BRIEF.md
# Zoned bus bandwidth monitor

The block measures how much data passes a bus point during a programmable sampling window. Byte-count beats arrive on a valid/ready stream. The window ends after a set number of clock ticks. The total of that window is then scaled to count units, and the count is sorted into one of four bandwidth zones using three thresholds. For each zone, a programmable rule set increments or clears per-zone hit counters. A zone's status bit is raised when its hit counter reaches the zone's repeat count. The block also keeps the largest count seen in each zone. Zone status bits are gated by per-zone enables into a global pending latch. A global enable then drives the single interrupt line.

Software configures and services the block through a word-addressed register port, with 4-bit address and 32-bit data. Writes take effect at the clock edge and reads are combinational. The byte stream has no back-pressure. `cnt_ready` is high in every cycle, so a beat transfers whenever `cnt_valid` is high. Beats offered while monitoring is stopped are accepted and discarded.

Top module: `bwz_monitor`

## Requirements
- R1: After reset all configuration registers, zone status, global latch, hit counters and peak registers are zero, `irq` is low and `cnt_ready` is high.
- R2: While CTRL (address 0) bit 0 is set, a window ends on the cycle in which the elapsed tick count reaches WINDOW (address 2; 0 acts as 1). The bytes of every valid beat, including that last cycle, are summed with saturation at 2^(CNT_W+UNIT_SHIFT)-1, and the count is the sum shifted right by UNIT_SHIFT. The sum then restarts at zero. With bit 0 clear, the timer holds and beats are discarded.
- R3: The count is classified in the cycle after the window ends. Zone 3 applies if the count is greater than HI (address 5), zone 2 if greater than MID (address 4), zone 1 if greater than LO (address 3), and zone 0 otherwise.
- R4: RULES (address 6) byte k, bits 8k+7..8k, is the action set applied when zone k is classified. In that byte, bit 2t clears zone t's hit counter and bit 2t+1 increments it. Clear wins when both bits are set.
- R5: REPEAT (address 7) byte t is zone t's repeat count. An increment that brings zone t's hit counter to a value at or above it sets status bit t, visible from the next cycle. A repeat value of 0xFF never sets the bit.
- R6: PEAK t (address 12+t) holds the largest count classified into zone t since the last full clear.
- R7: FLUSH (address 1) bit 0 clears the window timer, the running sum, a pending classification and all hit counters. Bit 1 does the same and also zeroes the peaks. With LEVEL_CLR=0 the clear acts in the write cycle and FLUSH reads 0.
- R8: ZSTAT (address 8) bits 3..0 are the zone status bits. Each stays set until a 1 is written to the same bit of ZACK (address 9), and a new set in the same cycle wins. ZACK always reads 0.
- R9: ZSTAT bit 4 is the global latch. It is set the cycle after any status bit is set with its ZEN (address 10) bit set and is not being acknowledged in that cycle. A write of 1 to GACK (address 11) bit 0 clears the latch, and that clear wins. GACK reads 0, and `irq` equals the latch AND CTRL bit 1.
- R10: With LEVEL_CLR=1, FLUSH bits are stored and read back. They apply in every cycle, starting the cycle after the write, until 0 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the window tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_valid | input | 1 | Byte-count beat valid |
| cnt_ready | output | 1 | Always high; no back-pressure |
| cnt_bytes | input | BYTE_W | Bytes carried by the beat |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Interrupt, global latch gated by global enable |

## Verification
The assertions check these invariants in every cycle:
- Peaks never fall except during a full clear.
- A zone status bit stays set until it is acknowledged.
- A status bit rises only right after a classification that was not cleared.
- The global latch rises only when an enabled status bit was set the cycle before.

The exact window boundaries, saturation, the strict-greater zone edges, the action matrix with clear priority, repeat counts including 0xFF, and held-level clearing need directed scenarios. These scenarios are compared cycle by cycle against a behavioural model, for both clear modes at once.

// File: rtl/bwz_pkg.sv
package bwz_pkg;
  localparam int NZ = 4;
  localparam int AW = 4;
  localparam logic [AW-1:0] RA_CTRL   = 4'd0;
  localparam logic [AW-1:0] RA_FLUSH  = 4'd1;
  localparam logic [AW-1:0] RA_WIN    = 4'd2;
  localparam logic [AW-1:0] RA_LO     = 4'd3;
  localparam logic [AW-1:0] RA_MID    = 4'd4;
  localparam logic [AW-1:0] RA_HI     = 4'd5;
  localparam logic [AW-1:0] RA_RULES  = 4'd6;
  localparam logic [AW-1:0] RA_REPEAT = 4'd7;
  localparam logic [AW-1:0] RA_ZSTAT  = 4'd8;
  localparam logic [AW-1:0] RA_ZACK   = 4'd9;
  localparam logic [AW-1:0] RA_ZEN    = 4'd10;
  localparam logic [AW-1:0] RA_GACK   = 4'd11;
  localparam logic [AW-1:0] RA_PEAK0  = 4'd12;
  localparam logic [7:0]    RPT_OFF   = 8'hFF;
endpackage

// File: rtl/bwz_window.sv
module bwz_window #(
  parameter int WIN_W      = 24,
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 12,
  parameter int UNIT_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [WIN_W-1:0]  win,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_bytes,
  output logic              pend,
  output logic [CNT_W-1:0]  snap
);
  localparam int ACC_W = CNT_W + UNIT_SHIFT;
  localparam int SUM_W = ACC_W + 1;

  logic [WIN_W-1:0] tick;
  logic [ACC_W-1:0] acc, acc_in;
  logic [SUM_W-1:0] sum;
  logic             expire;

  always_comb begin
    sum    = {1'b0, acc} + SUM_W'(in_bytes);
    acc_in = !in_valid ? acc : (sum[ACC_W] ? '1 : sum[ACC_W-1:0]);
    expire = ({1'b0, tick} + 1'b1) >= {1'b0, win};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0;
      acc  <= '0;
      pend <= 1'b0;
      snap <= '0;
    end else if (clr) begin
      tick <= '0;
      acc  <= '0;
      pend <= 1'b0;
    end else if (run) begin
      if (expire) begin
        tick <= '0;
        acc  <= '0;
        pend <= 1'b1;
        snap <= acc_in[ACC_W-1:UNIT_SHIFT];
      end else begin
        tick <= tick + 1'b1;
        acc  <= acc_in;
        pend <= 1'b0;
      end
    end else begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/bwz_zones.sv
module bwz_zones
  import bwz_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pend,
  input  logic [CNT_W-1:0]    snap,
  input  logic                clr_run,
  input  logic                clr_all,
  input  logic [CNT_W-1:0]    lo,
  input  logic [CNT_W-1:0]    mid,
  input  logic [CNT_W-1:0]    hi,
  input  logic [31:0]         rules,
  input  logic [31:0]         rpt,
  input  logic [NZ-1:0]       zack,
  output logic [NZ-1:0]       zst,
  output logic [NZ*CNT_W-1:0] peak_flat
);
  logic          clr_any, upd;
  logic [1:0]    zsel;
  logic [7:0]    act;
  logic [NZ-1:0] fire;

  assign clr_any = clr_run | clr_all;
  assign upd     = pend & ~clr_any;

  always_comb begin
    if (snap > hi)       zsel = 2'd3;
    else if (snap > mid) zsel = 2'd2;
    else if (snap > lo)  zsel = 2'd1;
    else                 zsel = 2'd0;
    act = rules[{zsel, 3'b000} +: 8];
  end

  for (genvar t = 0; t < NZ; t++) begin : g_zone
    logic [7:0]       hit, hit_inc, rpt_t;
    logic [CNT_W-1:0] pk;
    logic             st, do_clr, do_inc;

    assign do_clr  = act[2*t];
    assign do_inc  = act[2*t+1];
    assign rpt_t   = rpt[8*t +: 8];
    // hit counters saturate rather than wrap
    assign hit_inc = (hit == 8'hFF) ? hit : hit + 8'd1;
    assign fire[t] = upd & ~do_clr & do_inc & (rpt_t != RPT_OFF) & (hit_inc >= rpt_t);
    assign zst[t]  = st;
    assign peak_flat[t*CNT_W +: CNT_W] = pk;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit <= '0;
        pk  <= '0;
        st  <= 1'b0;
      end else begin
        if (clr_any)              hit <= '0;
        else if (upd && do_clr)   hit <= '0;
        else if (upd && do_inc)   hit <= hit_inc;

        if (clr_all)                                  pk <= '0;
        else if (upd && zsel == 2'(t) && snap > pk)   pk <= snap;

        st <= fire[t] | (st & ~zack[t]);
      end
    end
  end
endmodule

// File: rtl/bwz_regs.sv
module bwz_regs
  import bwz_pkg::*;
#(
  parameter int WIN_W     = 24,
  parameter int CNT_W     = 12,
  parameter bit LEVEL_CLR = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [31:0]         wdata,
  input  logic [NZ-1:0]       zst,
  input  logic                gst,
  input  logic [NZ*CNT_W-1:0] peak_flat,
  output logic [31:0]         rdata,
  output logic                run,
  output logic                gie,
  output logic [WIN_W-1:0]    win,
  output logic [CNT_W-1:0]    lo,
  output logic [CNT_W-1:0]    mid,
  output logic [CNT_W-1:0]    hi,
  output logic [31:0]         rules,
  output logic [31:0]         rpt,
  output logic [NZ-1:0]       zen,
  output logic                clr_run,
  output logic                clr_all,
  output logic [NZ-1:0]       zack,
  output logic                gack
);
  logic [15:0] sel;
  logic [1:0]  flush_rd;

  assign sel  = we ? (16'd1 << addr) : 16'd0;
  assign zack = sel[RA_ZACK] ? wdata[NZ-1:0] : '0;
  assign gack = sel[RA_GACK] & wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; gie <= 1'b0; win <= '0;
      lo <= '0; mid <= '0; hi <= '0;
      rules <= '0; rpt <= '0; zen <= '0;
    end else begin
      if (sel[RA_CTRL])   {gie, run} <= wdata[1:0];
      if (sel[RA_WIN])    win   <= wdata[WIN_W-1:0];
      if (sel[RA_LO])     lo    <= wdata[CNT_W-1:0];
      if (sel[RA_MID])    mid   <= wdata[CNT_W-1:0];
      if (sel[RA_HI])     hi    <= wdata[CNT_W-1:0];
      if (sel[RA_RULES])  rules <= wdata;
      if (sel[RA_REPEAT]) rpt   <= wdata;
      if (sel[RA_ZEN])    zen   <= wdata[NZ-1:0];
    end
  end

  if (LEVEL_CLR) begin : g_level
    logic [1:0] flush_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flush_q <= '0;
      else if (sel[RA_FLUSH])  flush_q <= wdata[1:0];
    end
    assign {clr_all, clr_run} = flush_q;
    assign flush_rd = flush_q;
  end else begin : g_pulse
    assign {clr_all, clr_run} = sel[RA_FLUSH] ? wdata[1:0] : 2'b00;
    assign flush_rd = 2'b00;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL:   rdata = {30'd0, gie, run};
      RA_FLUSH:  rdata = {30'd0, flush_rd};
      RA_WIN:    rdata = 32'(win);
      RA_LO:     rdata = 32'(lo);
      RA_MID:    rdata = 32'(mid);
      RA_HI:     rdata = 32'(hi);
      RA_RULES:  rdata = rules;
      RA_REPEAT: rdata = rpt;
      RA_ZSTAT:  rdata = 32'({gst, zst});
      RA_ZEN:    rdata = 32'(zen);
      default: begin
        for (int i = 0; i < NZ; i++)
          if (addr == RA_PEAK0 + AW'(i)) rdata = 32'(peak_flat[i*CNT_W +: CNT_W]);
      end
    endcase
  end
endmodule

// File: rtl/bwz_monitor.sv
module bwz_monitor
  import bwz_pkg::*;
#(
  parameter int WIN_W      = 24,
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 12,
  parameter int UNIT_SHIFT = 4,
  parameter bit LEVEL_CLR  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_valid,
  output logic              cnt_ready,
  input  logic [BYTE_W-1:0] cnt_bytes,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic                run, gie, clr_run, clr_all, clr_any, gack, pend, gst;
  logic [WIN_W-1:0]    win;
  logic [CNT_W-1:0]    lo, mid, hi, snap;
  logic [31:0]         rules, rpt;
  logic [NZ-1:0]       zen, zack, zst;
  logic [NZ*CNT_W-1:0] peak_flat;

  assign cnt_ready = 1'b1;
  assign clr_any   = clr_run | clr_all;

  bwz_regs #(.WIN_W(WIN_W), .CNT_W(CNT_W), .LEVEL_CLR(LEVEL_CLR)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .zst(zst), .gst(gst), .peak_flat(peak_flat), .rdata(reg_rdata),
    .run(run), .gie(gie), .win(win), .lo(lo), .mid(mid), .hi(hi),
    .rules(rules), .rpt(rpt), .zen(zen), .clr_run(clr_run), .clr_all(clr_all),
    .zack(zack), .gack(gack));

  bwz_window #(.WIN_W(WIN_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .UNIT_SHIFT(UNIT_SHIFT)) u_win (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_any), .win(win),
    .in_valid(cnt_valid), .in_bytes(cnt_bytes), .pend(pend), .snap(snap));

  bwz_zones #(.CNT_W(CNT_W)) u_zones (
    .clk(clk), .rst_n(rst_n), .pend(pend), .snap(snap), .clr_run(clr_run),
    .clr_all(clr_all), .lo(lo), .mid(mid), .hi(hi), .rules(rules), .rpt(rpt),
    .zack(zack), .zst(zst), .peak_flat(peak_flat));

  // global latch: a status bit being acknowledged this cycle cannot set it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gst <= 1'b0;
    else if (gack) gst <= 1'b0;
    else if (|(zst & zen & ~zack)) gst <= 1'b1;
  end

  assign irq = gie & gst;
endmodule

// File: rtl/bwz_monitor_chk.sv
module bwz_monitor_chk #(
  parameter int CNT_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pend,
  input logic               clr_any,
  input logic               clr_all,
  input logic [3:0]         zst,
  input logic [3:0]         zack,
  input logic [3:0]         zen,
  input logic               gst,
  input logic [4*CNT_W-1:0] peak_flat
);
  for (genvar i = 0; i < 4; i++) begin : g_chk
    assert_peak_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all |=> peak_flat[i*CNT_W +: CNT_W] >= $past(peak_flat[i*CNT_W +: CNT_W]));

    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (zst[i] && !zack[i]) |=> zst[i]);

    assert_status_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(zst[i]) |-> $past(pend && !clr_any));
  end

  assert_global_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gst) |-> $past(|(zst & zen)));
endmodule

bind bwz_monitor bwz_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .clr_any(clr_any), .clr_all(clr_all),
  .zst(zst), .zack(zack), .zen(zen), .gst(gst), .peak_flat(peak_flat));

// File: tb/test_bwz_monitor.sv
`timescale 1ns/1ps
module ref_bwz #(parameter bit LEVEL = 1'b0) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic [7:0]  bytes,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic        irq_m,
  output logic [31:0] rdata_m
);
  int run, gie, win, lo, mid, hi, zen, zst, gst, tick, acc, snap, pend, flushq;
  logic [31:0] rules, rpt;
  int hit[4];
  int peak[4];

  always @(posedge clk or negedge rst_n) begin
    int cr, ca, ack, gack, z, a, r, fire, ain, nz, ng;
    int nh[4];
    int np[4];
    if (!rst_n) begin
      run = 0; gie = 0; win = 0; lo = 0; mid = 0; hi = 0; zen = 0; zst = 0; gst = 0;
      tick = 0; acc = 0; snap = 0; pend = 0; flushq = 0; rules = 0; rpt = 0;
      for (int t = 0; t < 4; t++) begin hit[t] = 0; peak[t] = 0; end
    end else begin
      if (LEVEL) begin cr = flushq & 1; ca = (flushq >> 1) & 1; end
      else begin
        cr = (we && addr == 1 && wdata[0]) ? 1 : 0;
        ca = (we && addr == 1 && wdata[1]) ? 1 : 0;
      end
      ack  = (we && addr == 9) ? int'(wdata[3:0]) : 0;
      gack = (we && addr == 11 && wdata[0]) ? 1 : 0;
      fire = 0;
      for (int t = 0; t < 4; t++) begin nh[t] = hit[t]; np[t] = peak[t]; end
      if (pend != 0 && cr == 0 && ca == 0) begin
        z = (snap > hi) ? 3 : (snap > mid) ? 2 : (snap > lo) ? 1 : 0;
        a = int'((rules >> (8 * z)) & 32'hFF);
        for (int t = 0; t < 4; t++) begin
          r = int'((rpt >> (8 * t)) & 32'hFF);
          if (((a >> (2 * t)) & 1) != 0) nh[t] = 0;
          else if (((a >> (2 * t + 1)) & 1) != 0) begin
            nh[t] = (hit[t] < 255) ? hit[t] + 1 : 255;
            if (r != 255 && nh[t] >= r) fire = fire | (1 << t);
          end
        end
        if (snap > peak[z]) np[z] = snap;
      end
      if (cr != 0 || ca != 0) for (int t = 0; t < 4; t++) nh[t] = 0;
      if (ca != 0) for (int t = 0; t < 4; t++) np[t] = 0;
      ng = (gack != 0) ? 0 : ((gst != 0 || (zst & zen & ~ack & 15) != 0) ? 1 : 0);
      nz = (zst & ~ack & 15) | fire;
      if (cr != 0 || ca != 0) begin tick = 0; acc = 0; pend = 0; end
      else if (run != 0) begin
        ain = (valid) ? acc + int'(bytes) : acc;
        if (ain > 65535) ain = 65535;
        if (tick + 1 >= win) begin snap = ain >> 4; pend = 1; tick = 0; acc = 0; end
        else begin tick = tick + 1; acc = ain; pend = 0; end
      end else pend = 0;
      if (we) begin
        case (addr)
          4'd0: begin run = int'(wdata[0]); gie = int'(wdata[1]); end
          4'd1: flushq = int'(wdata[1:0]);
          4'd2: win = int'(wdata[23:0]);
          4'd3: lo = int'(wdata[11:0]);
          4'd4: mid = int'(wdata[11:0]);
          4'd5: hi = int'(wdata[11:0]);
          4'd6: rules = wdata;
          4'd7: rpt = wdata;
          4'd10: zen = int'(wdata[3:0]);
          default: ;
        endcase
      end
      for (int t = 0; t < 4; t++) begin hit[t] = nh[t]; peak[t] = np[t]; end
      zst = nz; gst = ng;
    end
  end

  assign irq_m = (gie != 0) && (gst != 0);

  always_comb begin
    case (addr)
      4'd0: rdata_m = 32'(gie * 2 + run);
      4'd1: rdata_m = LEVEL ? 32'(flushq) : 32'd0;
      4'd2: rdata_m = 32'(win);
      4'd3: rdata_m = 32'(lo);
      4'd4: rdata_m = 32'(mid);
      4'd5: rdata_m = 32'(hi);
      4'd6: rdata_m = rules;
      4'd7: rdata_m = rpt;
      4'd8: rdata_m = 32'(gst * 16 + zst);
      4'd10: rdata_m = 32'(zen);
      4'd12: rdata_m = 32'(peak[0]);
      4'd13: rdata_m = 32'(peak[1]);
      4'd14: rdata_m = 32'(peak[2]);
      4'd15: rdata_m = 32'(peak[3]);
      default: rdata_m = 32'd0;
    endcase
  end
endmodule

module test_bwz_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_valid = 1'b0;
  logic [7:0]  cnt_bytes = 8'd0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        rdy_p, rdy_l, irq_p, irq_l, irq_mp, irq_ml;
  logic [31:0] rd_p, rd_l, rd_mp, rd_ml;
  int          n_tests = 0, n_fail = 0;
  bit          checking = 1'b0, done = 1'b0;
  string       req_tag = "R1";
  logic [3:0]  rot = 4'd0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  bwz_monitor i_bwz_monitor (
    .clk(clk), .rst_n(rst_n), .cnt_valid(cnt_valid), .cnt_ready(rdy_p), .cnt_bytes(cnt_bytes),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_p), .irq(irq_p));

  bwz_monitor #(.LEVEL_CLR(1'b1)) i_bwz_monitor_lvl (
    .clk(clk), .rst_n(rst_n), .cnt_valid(cnt_valid), .cnt_ready(rdy_l), .cnt_bytes(cnt_bytes),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_l), .irq(irq_l));

  ref_bwz #(.LEVEL(1'b0)) u_ref_p (.clk(clk), .rst_n(rst_n), .valid(cnt_valid), .bytes(cnt_bytes),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .irq_m(irq_mp), .rdata_m(rd_mp));
  ref_bwz #(.LEVEL(1'b1)) u_ref_l (.clk(clk), .rst_n(rst_n), .valid(cnt_valid), .bytes(cnt_bytes),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .irq_m(irq_ml), .rdata_m(rd_ml));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the reference model, just before each rising edge
  always begin
    @(negedge clk);
    #3;
    if (checking && rst_n) begin
      chk({req_tag, " pulse irq/rdata/ready"}, {irq_p, rdy_p, rd_p[29:0]}, {irq_mp, 1'b1, rd_mp[29:0]});
      chk({req_tag, " level irq/rdata/ready"}, {irq_l, rdy_l, rd_l[29:0]}, {irq_ml, 1'b1, rd_ml[29:0]});
      if (rd_p[31:30] !== rd_mp[31:30] || rd_l[31:30] !== rd_ml[31:30])
        chk({req_tag, " rdata top bits"}, {rd_p[31:30], rd_l[31:30]}, {rd_mp[31:30], rd_ml[31:30]});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic traffic(input int n, input logic [7:0] b, input logic v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_valid = v; cnt_bytes = b; reg_addr = rot; rot = rot + 4'd1;
    end
    @(negedge clk);
    cnt_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1;
    chk(tag, rd_p, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    checking = 1'b1;
    // R1: reset state
    req_tag = "R1";
    rd_chk("R1 ctrl after reset", 4'd0, 32'd0);
    rd_chk("R1 zstat after reset", 4'd8, 32'd0);
    rd_chk("R1 peak3 after reset", 4'd15, 32'd0);
    chk("R1 irq after reset", {31'd0, irq_p}, 32'd0);
    chk("R1 ready after reset", {31'd0, rdy_p}, 32'd1);
    traffic(16, 8'd0, 1'b0);

    // configuration
    wr(4'd2, 32'd8); wr(4'd3, 32'd2); wr(4'd4, 32'd5); wr(4'd5, 32'd9);
    wr(4'd6, 32'h9525_0901); wr(4'd7, 32'h01FF_03FF); wr(4'd10, 32'hF);

    // R2: traffic while stopped is discarded
    req_tag = "R2";
    traffic(20, 8'd200, 1'b1);
    rd_chk("R2 no peak while stopped", 4'd15, 32'd0);
    wr(4'd0, 32'd3);

    // R3: zone edges, counts 1,2,3,5,6,9,10 and back
    req_tag = "R3";
    begin
      logic [7:0] pat [10] = '{8'd2, 8'd4, 8'd6, 8'd10, 8'd12, 8'd18, 8'd20, 8'd3, 8'd11, 8'd19};
      foreach (pat[k]) traffic(8, pat[k], 1'b1);
    end

    // R5: three zone-1 windows in a row reach repeat count 3; zone 3 repeat 1
    req_tag = "R5";
    traffic(8, 8'd6, 1'b1); traffic(8, 8'd6, 1'b1); traffic(8, 8'd6, 1'b1);
    traffic(8, 8'd6, 1'b1);
    traffic(8, 8'd20, 1'b1);

    // R8: stop, acknowledge local then global, status reads zero
    req_tag = "R8";
    wr(4'd0, 32'd2);
    traffic(12, 8'd0, 1'b0);
    wr(4'd9, 32'hF);
    rd_chk("R8 zack reads zero", 4'd9, 32'd0);
    wr(4'd11, 32'd1);
    rd_chk("R9 gack reads zero", 4'd11, 32'd0);
    rd_chk("R8 zstat after acks", 4'd8, 32'd0);
    chk("R9 no reassert after acks", {31'd0, irq_p}, 32'd0);

    // R9: masked zone, then gated output, then release of gating
    req_tag = "R9";
    wr(4'd10, 32'h2);
    wr(4'd0, 32'd3);
    traffic(8, 8'd20, 1'b1);
    traffic(4, 8'd0, 1'b0);
    wr(4'd10, 32'hF);
    wr(4'd0, 32'd1);
    traffic(8, 8'd20, 1'b1);
    traffic(4, 8'd0, 1'b0);
    wr(4'd0, 32'd2);
    traffic(4, 8'd0, 1'b0);
    wr(4'd9, 32'hF);
    wr(4'd11, 32'd1);
    traffic(6, 8'd0, 1'b0);

    // R4: zone 3 rule with both clear and increment on itself never fires
    req_tag = "R4";
    wr(4'd6, 32'hC025_0901);
    wr(4'd0, 32'd3);
    traffic(8, 8'd20, 1'b1); traffic(8, 8'd20, 1'b1);
    traffic(8, 8'd12, 1'b1);
    wr(4'd6, 32'h9525_0901);
    wr(4'd7, 32'h01FF_FF00);
    traffic(8, 8'd6, 1'b1); traffic(8, 8'd12, 1'b1);
    wr(4'd7, 32'h01FF_03FF);

    // R2: window 0 acts as 1, then saturation over a long window
    req_tag = "R2";
    wr(4'd2, 32'd0);
    traffic(10, 8'd50, 1'b1);
    wr(4'd1, 32'd2); wr(4'd1, 32'd0);
    wr(4'd2, 32'd300);
    traffic(302, 8'd255, 1'b1);
    wr(4'd0, 32'd2);
    traffic(4, 8'd0, 1'b0);
    rd_chk("R2 saturated count in peak3", 4'd15, 32'd4095);
    rd_chk("R6 zone0 peak untouched", 4'd12, 32'd0);

    // R7: mid-window running clear, then full clear zeroes peaks
    req_tag = "R7";
    wr(4'd2, 32'd8);
    wr(4'd0, 32'd3);
    traffic(5, 8'd20, 1'b1);
    wr(4'd1, 32'd1);
    rd_chk("R7 flush reads zero in pulse mode", 4'd1, 32'd0);
    wr(4'd1, 32'd0);
    traffic(16, 8'd12, 1'b1);
    wr(4'd1, 32'd2);
    wr(4'd1, 32'd0);
    wr(4'd0, 32'd2);
    rd_chk("R7 peak3 after full clear", 4'd15, 32'd0);
    rd_chk("R7 peak2 after full clear", 4'd14, 32'd0);
    wr(4'd9, 32'hF); wr(4'd11, 32'd1);

    // R10: held clear freezes the level instance only while held
    req_tag = "R10";
    wr(4'd0, 32'd3);
    wr(4'd1, 32'd1);
    traffic(24, 8'd20, 1'b1);
    wr(4'd1, 32'd2);
    traffic(12, 8'd12, 1'b1);
    wr(4'd1, 32'd0);
    traffic(24, 8'd20, 1'b1);

    // R6: irregular traffic with gaps
    req_tag = "R6";
    wr(4'd2, 32'd16);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cnt_valid = lfsr[0]; cnt_bytes = {3'd0, lfsr[7:3]}; reg_addr = rot; rot = rot + 4'd1;
      if (i % 97 == 96) begin reg_we = 1'b1; reg_addr = 4'd9; reg_wdata = 32'hF; end
      else reg_we = 1'b0;
    end
    @(negedge clk);
    cnt_valid = 1'b0; reg_we = 1'b0;
    traffic(20, 8'd0, 1'b0);

    checking = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule